// File: doc/BRIEF.md
# Hotspot CAM Delta Encoder

This block sits between a memory bank read port and a compute unit. It holds a small fully associative table with at most one reference ("hotspot") word per memory region. Each read word arrives on a valid/ready stream with a region tag. The block searches the table by that tag. On a match, it emits the XOR of the word and the stored hotspot. Words that resemble their region's hotspot therefore produce deltas that are mostly zero, which a downstream stage can use to skip work.

When no entry holds the region, the incoming word is installed as the new hotspot. Entries are replaced in round-robin order, and the word leaves unchanged with the hit flag clear. Two further controls act on the table. A synchronous clear empties it. A preload port writes a hotspot for a chosen region ahead of traffic. A single output register stage carries the delta, the table index used and the hit flag, and it applies backpressure without dropping words.

Top module: `hotspot_delta_enc`

## Requirements
- R1: After reset `out_valid_o` is 0, `in_ready_o` is 1 and the table is empty, so the first word of any region misses at index 0.
- R2: A miss outputs the input word unchanged on `out_delta_o`, with `out_hit_o`=0 and `out_idx_o` equal to the slot that receives the word.
- R3: A missed word becomes its region's hotspot, so the next word of that region hits and yields `in_data_i` XOR that word.
- R4: A hit outputs `in_data_i` XOR the stored hotspot, with `out_hit_o`=1 and `out_idx_o` equal to the matching slot, and leaves the stored hotspot unchanged.
- R5: Installs take slots 0,1,…,ENTRIES-1 and then wrap to 0. The evicted region then misses.
- R6: While `out_valid_o`=1 and `out_ready_i`=0, the outputs hold stable and `in_ready_o`=0. No accepted word is lost or duplicated.
- R7: `clr_i` invalidates every entry and returns the round-robin slot to 0. `in_ready_o` is 0 in a cycle with `clr_i` high.
- R8: `pl_we_i` writes `pl_data_i` as the hotspot of `pl_rid_i`. If the region is present, its slot is overwritten in place and the round-robin slot is unchanged. Otherwise the word takes the round-robin slot, which then advances. `in_ready_o` is 0 in a cycle with `pl_we_i` high.
- R9: With `out_ready_i` held at 1, one word is accepted and one delta emitted every cycle, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous table clear |
| pl_we_i | input | 1 | Hotspot preload strobe |
| pl_rid_i | input | RID_W | Preload region ID |
| pl_data_i | input | DATA_W | Preload hotspot word |
| in_valid_i | input | 1 | Read word valid |
| in_ready_o | output | 1 | Read word accepted when valid |
| in_rid_i | input | RID_W | Region ID of read word |
| in_data_i | input | DATA_W | Read word |
| out_valid_o | output | 1 | Delta valid |
| out_ready_i | input | 1 | Downstream ready |
| out_delta_o | output | DATA_W | XOR delta, or raw word on miss |
| out_idx_o | output | IDX_W | Table slot used |
| out_hit_o | output | 1 | Region matched a stored hotspot |

## Verification
The bench builds the block with its defaults: 16-bit words, 4-bit region IDs and 8 entries. With these values, 16 region IDs compete for 8 slots. A ninth distinct region therefore forces the round-robin pointer to wrap and evict a live hotspot, so eviction followed by a re-miss can be reached in a few dozen cycles. The 16-bit words allow XOR deltas with only a low bit set to be checked against a full-width miss pass-through.

// File: rtl/hde_pkg.sv
package hde_pkg;
  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_RID_W   = 4;
  localparam int unsigned DEF_ENTRIES = 8;

  typedef enum logic [1:0] {
    TOP_NONE    = 2'd0,
    TOP_CLEAR   = 2'd1,
    TOP_PRELOAD = 2'd2,
    TOP_INSTALL = 2'd3
  } tbl_op_e;
endpackage

// File: rtl/hde_match.sv
module hde_match #(
  parameter int unsigned ENTRIES = hde_pkg::DEF_ENTRIES,
  parameter int unsigned RID_W   = hde_pkg::DEF_RID_W,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            vld_i,
  input  logic [ENTRIES-1:0][RID_W-1:0] rid_i,
  input  logic [RID_W-1:0]              key_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [ENTRIES-1:0] eq;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign eq[e] = vld_i[e] && (rid_i[e] == key_i);
  end

  // at most one entry per region, so lowest index is just a tie-free pick
  always_comb begin
    idx_o = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (eq[e]) idx_o = IDX_W'(e);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/hde_victim.sv
module hde_victim #(
  parameter int unsigned ENTRIES = hde_pkg::DEF_ENTRIES,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (clr_i) begin
      ptr_q <= '0;
    end else if (adv_i) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/hde_table.sv
module hde_table
  import hde_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned RID_W   = DEF_RID_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              pl_we_i,
  input  logic [RID_W-1:0]  pl_rid_i,
  input  logic [DATA_W-1:0] pl_data_i,
  input  logic [RID_W-1:0]  lk_rid_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic              ins_en_i,
  input  logic [DATA_W-1:0] ins_data_i,
  output logic [IDX_W-1:0]  victim_o
);
  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0][RID_W-1:0]  rid_q;
  logic [ENTRIES-1:0][DATA_W-1:0] dat_q;

  logic             pl_hit;
  logic [IDX_W-1:0] pl_idx;
  tbl_op_e          op;
  logic             wr_en, adv;
  logic [IDX_W-1:0] wr_idx;
  logic [RID_W-1:0] wr_rid;
  logic [DATA_W-1:0] wr_dat;

  hde_match #(.ENTRIES(ENTRIES), .RID_W(RID_W), .IDX_W(IDX_W)) u_lk_match (
    .vld_i(vld_q), .rid_i(rid_q), .key_i(lk_rid_i),
    .hit_o(lk_hit_o), .idx_o(lk_idx_o)
  );

  hde_match #(.ENTRIES(ENTRIES), .RID_W(RID_W), .IDX_W(IDX_W)) u_pl_match (
    .vld_i(vld_q), .rid_i(rid_q), .key_i(pl_rid_i),
    .hit_o(pl_hit), .idx_o(pl_idx)
  );

  hde_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .adv_i(adv), .ptr_o(victim_o)
  );

  // clear dominates preload, preload dominates stream install
  always_comb begin
    if (clr_i)         op = TOP_CLEAR;
    else if (pl_we_i)  op = TOP_PRELOAD;
    else if (ins_en_i) op = TOP_INSTALL;
    else               op = TOP_NONE;
  end

  always_comb begin
    wr_en  = 1'b0;
    adv    = 1'b0;
    wr_idx = victim_o;
    wr_rid = lk_rid_i;
    wr_dat = ins_data_i;
    unique case (op)
      TOP_PRELOAD: begin
        wr_en  = 1'b1;
        wr_rid = pl_rid_i;
        wr_dat = pl_data_i;
        if (pl_hit) wr_idx = pl_idx;
        else        adv    = 1'b1;
      end
      TOP_INSTALL: begin
        wr_en = 1'b1;
        adv   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rid_q <= '0;
      dat_q <= '0;
    end else if (op == TOP_CLEAR) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
      rid_q[wr_idx] <= wr_rid;
      dat_q[wr_idx] <= wr_dat;
    end
  end

  assign lk_data_o = dat_q[lk_idx_o];
endmodule

// File: rtl/hde_out_reg.sv
module hde_out_reg #(
  parameter int unsigned DATA_W = hde_pkg::DEF_DATA_W,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] delta_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              hit_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] delta_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      delta_o <= '0;
      idx_o   <= '0;
      hit_o   <= 1'b0;
    end else begin
      if (ld_i)         valid_o <= 1'b1;
      else if (ready_i) valid_o <= 1'b0;
      if (ld_i) begin
        delta_o <= delta_i;
        idx_o   <= idx_i;
        hit_o   <= hit_i;
      end
    end
  end
endmodule

// File: rtl/hotspot_delta_enc.sv
module hotspot_delta_enc
  import hde_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned RID_W   = DEF_RID_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              pl_we_i,
  input  logic [RID_W-1:0]  pl_rid_i,
  input  logic [DATA_W-1:0] pl_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [RID_W-1:0]  in_rid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_delta_o,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic              out_hit_o
);
  logic              fire;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx, victim;
  logic [DATA_W-1:0] lk_data, delta;
  logic [IDX_W-1:0]  sel_idx;

  // table maintenance owns the cycle; stream waits
  assign in_ready_o = (!out_valid_o || out_ready_i) && !clr_i && !pl_we_i;
  assign fire       = in_valid_i && in_ready_o;

  hde_table #(.DATA_W(DATA_W), .RID_W(RID_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .pl_we_i   (pl_we_i),
    .pl_rid_i  (pl_rid_i),
    .pl_data_i (pl_data_i),
    .lk_rid_i  (in_rid_i),
    .lk_hit_o  (lk_hit),
    .lk_idx_o  (lk_idx),
    .lk_data_o (lk_data),
    .ins_en_i  (fire && !lk_hit),
    .ins_data_i(in_data_i),
    .victim_o  (victim)
  );

  assign delta   = lk_hit ? (in_data_i ^ lk_data) : in_data_i;
  assign sel_idx = lk_hit ? lk_idx : victim;

  hde_out_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (fire),
    .delta_i(delta),
    .idx_i  (sel_idx),
    .hit_i  (lk_hit),
    .ready_i(out_ready_i),
    .valid_o(out_valid_o),
    .delta_o(out_delta_o),
    .idx_o  (out_idx_o),
    .hit_o  (out_hit_o)
  );
endmodule

// File: rtl/hde_checker.sv
module hde_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              pl_we_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_delta_o,
  input logic [IDX_W-1:0]  out_idx_o,
  input logic              out_hit_o
);
  logic seen_fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       seen_fire_q <= 1'b0;
    else if (in_valid_i && in_ready_o) seen_fire_q <= 1'b1;
  end

  AST_IDLE_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_fire_q |-> !out_valid_o); // R1

  AST_MISS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_hit_o || out_delta_o == $past(in_data_i))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_delta_o) && $stable(out_idx_o) && $stable(out_hit_o))); // R6

  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o); // R6

  AST_CLR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !in_ready_o); // R7

  AST_PL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_we_i |-> !in_ready_o); // R8

  AST_FIRE_EMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o); // R9
endmodule

bind hotspot_delta_enc hde_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_hde_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .pl_we_i    (pl_we_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .in_data_i  (in_data_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_delta_o(out_delta_o),
  .out_idx_o  (out_idx_o),
  .out_hit_o  (out_hit_o)
);

// File: tb/hotspot_delta_enc_bench.sv
module hotspot_delta_enc_bench;
  localparam int DW = 16;
  localparam int RW = 4;
  localparam int NE = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0, pl_we = 1'b0;
  logic [RW-1:0] pl_rid = '0;
  logic [DW-1:0] pl_data = '0;
  logic          in_valid = 1'b0, in_ready;
  logic [RW-1:0] in_rid = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_ready = 1'b1;
  logic [DW-1:0] out_delta;
  logic [IW-1:0] out_idx;
  logic          out_hit;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hotspot_delta_enc #(.DATA_W(DW), .RID_W(RW), .ENTRIES(NE)) u_hotspot_delta_enc (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .pl_we_i(pl_we), .pl_rid_i(pl_rid),
    .pl_data_i(pl_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_rid_i(in_rid), .in_data_i(in_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_delta_o(out_delta), .out_idx_o(out_idx),
    .out_hit_o(out_hit)
  );

  // reference table built from the requirements
  bit            m_v   [NE];
  logic [RW-1:0] m_rid [NE];
  logic [DW-1:0] m_dat [NE];
  int            m_ptr;

  function automatic void m_clear();
    for (int e = 0; e < NE; e++) m_v[e] = 1'b0;
    m_ptr = 0;
  endfunction

  function automatic int m_find(logic [RW-1:0] r);
    for (int e = 0; e < NE; e++) if (m_v[e] && m_rid[e] == r) return e;
    return -1;
  endfunction

  function automatic void m_put(int e, logic [RW-1:0] r, logic [DW-1:0] d);
    m_v[e] = 1'b1; m_rid[e] = r; m_dat[e] = d;
  endfunction

  function automatic void m_step(logic [RW-1:0] r, logic [DW-1:0] d,
                                 output logic [DW-1:0] ed, output int ei, output bit eh);
    int f = m_find(r);
    if (f >= 0) begin
      ed = d ^ m_dat[f]; ei = f; eh = 1'b1;
    end else begin
      ed = d; ei = m_ptr; eh = 1'b0;
      m_put(m_ptr, r, d);
      m_ptr = (m_ptr + 1) % NE;
    end
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_beat(string req, logic [DW-1:0] ed, int ei, bit eh);
    chk(req, "out_valid", out_valid, 1);
    chk(req, "delta", out_delta, ed);
    chk(req, "idx", out_idx, ei);
    chk(req, "hit", out_hit, eh);
  endtask

  // one word through the block; outputs checked at the negedge after acceptance
  task automatic xfer(string req, logic [RW-1:0] r, logic [DW-1:0] d);
    logic [DW-1:0] ed; int ei; bit eh;
    @(negedge clk);
    in_valid = 1'b1; in_rid = r; in_data = d;
    #0.1;
    while (!in_ready) @(negedge clk);
    m_step(r, d, ed, ei, eh);
    @(negedge clk);
    in_valid = 1'b0;
    chk_beat(req, ed, ei, eh);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    #0.1;
    chk("R7", "in_ready during clear", in_ready, 0);
    @(negedge clk);
    clr = 1'b0;
    m_clear();
  endtask

  task automatic do_preload(logic [RW-1:0] r, logic [DW-1:0] d);
    int f;
    @(negedge clk);
    pl_we = 1'b1; pl_rid = r; pl_data = d;
    #0.1;
    chk("R8", "in_ready during preload", in_ready, 0);
    @(negedge clk);
    pl_we = 1'b0;
    f = m_find(r);
    if (f >= 0) m_put(f, r, d);
    else begin m_put(m_ptr, r, d); m_ptr = (m_ptr + 1) % NE; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "in_ready after reset", in_ready, 1);
    xfer("R1", 4'd9, 16'h7E01);  // empty table: miss at slot 0
  endtask

  task automatic t_miss_hit();
    do_clear();
    xfer("R2", 4'd3, 16'hA5A5);
    xfer("R3", 4'd3, 16'hA5A7);  // delta 0002 at slot 0
    xfer("R4", 4'd3, 16'hFFFF);  // delta 5A5A: hotspot unchanged
    xfer("R4", 4'd3, 16'hA5A5);  // delta 0000
    xfer("R2", 4'd7, 16'h0F0F);  // second region miss, slot 1
  endtask

  task automatic t_round_robin();
    do_clear();
    for (int r = 0; r < NE; r++) xfer("R5", RW'(r), DW'(16'h1000 + r));
    xfer("R5", 4'd8, 16'hBEEF);  // wraps to slot 0, evicts region 0
    xfer("R5", 4'd0, 16'h1000);  // evicted: misses at slot 1
    xfer("R5", 4'd2, 16'h1003);  // region 2 still resident in slot 2
  endtask

  task automatic t_clear();
    xfer("R7", 4'd5, 16'h1111);
    xfer("R7", 4'd5, 16'h1113);
    do_clear();
    xfer("R7", 4'd5, 16'h2222);  // table empty, pointer back at 0
  endtask

  task automatic t_preload();
    do_clear();
    do_preload(4'd5, 16'h1234);
    xfer("R8", 4'd5, 16'h1235);  // hit slot 0, delta 0001
    do_preload(4'd5, 16'h0F00);  // overwrite in place
    xfer("R8", 4'd5, 16'h0F00);  // hit slot 0, delta 0000
    xfer("R8", 4'd6, 16'h4444);  // miss at slot 1
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] ea, eb; int ia, ib; bit ha, hb;
    do_clear();
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_rid = 4'd1; in_data = 16'hC0DE;
    m_step(4'd1, 16'hC0DE, ea, ia, ha);
    @(negedge clk);
    in_rid = 4'd1; in_data = 16'hC0DF;
    m_step(4'd1, 16'hC0DF, eb, ib, hb);
    for (int k = 0; k < 3; k++) begin
      #0.1;
      chk_beat("R6", ea, ia, ha);
      chk("R6", "in_ready under stall", in_ready, 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #0.1;
    chk("R6", "in_ready on release", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk_beat("R6", eb, ib, hb);
    @(negedge clk);
    chk("R6", "no duplicate", out_valid, 0);
  endtask

  task automatic t_stream();
    logic [DW-1:0] ed [9]; int ei [9]; bit eh [9];
    logic [RW-1:0] rs [9] = '{4'd2, 4'd2, 4'd4, 4'd2, 4'd4, 4'd11, 4'd11, 4'd2, 4'd4};
    do_clear();
    out_ready = 1'b1;
    for (int i = 0; i <= 9; i++) begin
      @(negedge clk);
      if (i > 0) chk_beat("R9", ed[i-1], ei[i-1], eh[i-1]);
      if (i < 9) begin
        in_valid = 1'b1; in_rid = rs[i]; in_data = DW'(16'h8000 ^ (i * 16'h0013));
        m_step(rs[i], in_data, ed[i], ei[i], eh[i]);
        #0.1;
        chk("R9", "in_ready streaming", in_ready, 1);
      end else in_valid = 1'b0;
    end
  endtask

  initial begin
    m_clear();
    #11 rst_n = 1'b1;
    t_reset();
    t_miss_hit();
    t_round_robin();
    t_clear();
    t_preload();
    t_backpressure();
    t_stream();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule